// File: doc/BRIEF.md
# Float to Unsigned Integer Converter

This unit turns one IEEE-754 binary32 or binary64 operand into an unsigned integer that is 32 or 64 bits wide. Each operand arrives with its own control fields: which precision it is, which result width is wanted, whether to truncate (chop), and a 2-bit rounding mode used when chop is off. The answer comes back with two exception flags, invalid and inexact, which hold only for that one result.

Special cases are sorted out before any rounding is done. A NaN of either sign saturates to all ones and is reported invalid. Any negative operand that is not zero is invalid and gives 0, even when its magnitude would round away. Negative zero is exempt: it gives 0 with no flag. Finite positive values are shifted into a fixed-point form and rounded. They saturate to all ones (invalid) when the rounded value does not fit the chosen width.

The block has one register stage and a valid/ready stream on each side. An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` from the next cycle on. While `out_valid` is high and `out_ready` is low, the result and flags stay frozen and `in_ready` is low, so back-pressure reaches the producer in the same cycle. `in_ready` is high whenever the output register is empty or is being drained in that cycle.

Top module: `f2u_conv`

## Requirements
- R1: An operand accepted on an edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_result`, `out_invalid` and `out_inexact` stay unchanged.
- R2: Field positions are as follows. A binary32 operand uses `in_operand[31:0]`: sign in bit 31, exponent in bits 30:23, fraction in bits 22:0. A binary64 operand uses sign in bit 63, exponent in bits 62:52, fraction in bits 51:0. `in_is_double`=1 selects binary64. `in_wide`=1 selects a 64-bit result. A 32-bit result sits in `out_result[31:0]` with bits 63:32 zero.
- R3: A NaN operand (exponent all ones, fraction non-zero), quiet or signalling and of either sign, gives all ones at the selected width with invalid=1 and inexact=0.
- R4: A negative operand that is not zero and not NaN gives 0 with invalid=1 and inexact=0. This covers negative infinity, negative denormals and negative values whose magnitude rounds to 0.
- R5: Negative zero gives 0 with both flags low.
- R6: Positive infinity, and any positive finite value whose rounded result exceeds the selected width, gives all ones at that width with invalid=1 and inexact=0.
- R7: Rounding mode `in_rmode` is encoded 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity. `in_chop`=1 forces toward zero whatever the mode.
- R8: An in-range result that discards non-zero fraction bits raises inexact. An exact result raises neither flag. Invalid and inexact are never high together.
- R9: Denormal operands are treated as their exact tiny value. A positive denormal gives 0 with inexact=1, or 1 with inexact=1 when rounding toward plus infinity.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and controls are valid |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_operand | input | 64 | Floating-point bit pattern (binary32 in low half) |
| in_is_double | input | 1 | 1: binary64 source, 0: binary32 source |
| in_wide | input | 1 | 1: 64-bit result, 0: 32-bit result |
| in_chop | input | 1 | 1: truncate toward zero |
| in_rmode | input | 2 | Rounding mode when not chopping |
| out_valid | output | 1 | Result and flags are valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Unsigned integer result |
| out_invalid | output | 1 | Invalid-operation flag for this result |
| out_inexact | output | 1 | Inexact flag for this result |

## Verification
The values 1.5 and 2.5 are run through all four rounding modes and through chop with the mode set to plus infinity. The tie at 2.5 separates nearest-even from round-half-up, and chop is shown to override the mode. Each special class (NaNs of both signs, both infinities, negative zero, small negatives, and denormals of both signs) is run at both result widths where it matters; this separates the sign-first rule from a round-first one. The operand 2^32−0.5 separates a carry that overflows after rounding from truncation, and 2^32 and 2^63 mark the exact edges of the 32-bit and 64-bit ranges. A stalled consumer shows that the result is held and that a second operand waits.

// File: rtl/f2u_pkg.sv
package f2u_pkg;
  localparam int SP_EXP    = 8;
  localparam int SP_FRAC   = 23;
  localparam int DP_EXP    = 11;
  localparam int DP_FRAC   = 52;
  localparam int OUT_W     = 64;
  localparam int NARROW_W  = 32;
  localparam int MANT_W    = DP_FRAC + 1;
  localparam int EXP_W     = 13;
  localparam int FRAC_BITS = OUT_W;
  localparam int FIX_W     = OUT_W + FRAC_BITS;
  localparam int SH_OFF    = FRAC_BITS - (MANT_W - 1);
  localparam int SH_MAX    = FIX_W - MANT_W;
  localparam int SH_W      = $clog2(SH_MAX + 1);

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_DOWN = 2'b10,
    RM_UP   = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             sign;
    logic             is_nan;
    logic             is_inf;
    logic             is_zero;
    logic [EXP_W-1:0] exp;   // unbiased, two's complement
    logic [MANT_W-1:0] mant; // hidden bit at MANT_W-1
  } unpacked_t;
endpackage

// File: rtl/f2u_field_dec.sv
module f2u_field_dec
  import f2u_pkg::*;
#(
  parameter int EW = SP_EXP,
  parameter int FW = SP_FRAC
) (
  input  logic [EW+FW:0] bits_i,
  output unpacked_t      fields_o
);
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int PAD  = MANT_W - 1 - FW;

  logic [EW-1:0] ef;
  logic [FW-1:0] ff;
  logic          ezero;
  logic          eones;

  always_comb begin
    ef    = bits_i[EW+FW-1:FW];
    ff    = bits_i[FW-1:0];
    ezero = (ef == '0);
    eones = (ef == '1);
    fields_o.sign    = bits_i[EW+FW];
    fields_o.is_nan  = eones && (ff != '0);
    fields_o.is_inf  = eones && (ff == '0);
    fields_o.is_zero = ezero && (ff == '0);
    // denormals use the minimum exponent with no hidden bit
    fields_o.exp  = ezero ? EXP_W'(1 - BIAS) : (EXP_W'(ef) - EXP_W'(BIAS));
    fields_o.mant = MANT_W'({~ezero, ff}) << PAD;
  end
endmodule

// File: rtl/f2u_align.sv
module f2u_align
  import f2u_pkg::*;
(
  input  unpacked_t        fields_i,
  output logic [OUT_W-1:0] int_o,
  output logic             guard_o,
  output logic             sticky_o,
  output logic             big_o
);
  logic signed [EXP_W-1:0] sh_s;
  logic [FIX_W-1:0]        fix;
  logic                    tiny;

  always_comb begin
    sh_s  = $signed(fields_i.exp) + $signed(EXP_W'(SH_OFF));
    tiny  = (sh_s < 0);
    big_o = (sh_s > $signed(EXP_W'(SH_MAX)));
    fix   = FIX_W'(fields_i.mant) << sh_s[SH_W-1:0];
    if (tiny) begin
      // value below 2^-(SH_OFF), so the half bit is zero
      int_o    = '0;
      guard_o  = 1'b0;
      sticky_o = |fields_i.mant;
    end else if (big_o) begin
      int_o    = '1;
      guard_o  = 1'b0;
      sticky_o = 1'b0;
    end else begin
      int_o    = fix[FIX_W-1:FRAC_BITS];
      guard_o  = fix[FRAC_BITS-1];
      sticky_o = |fix[FRAC_BITS-2:0];
    end
  end
endmodule

// File: rtl/f2u_round.sv
module f2u_round
  import f2u_pkg::*;
(
  input  logic [OUT_W-1:0] int_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  rmode_e           mode_i,
  input  logic             wide_i,
  output logic [OUT_W-1:0] val_o,
  output logic             ovf_o,
  output logic             inexact_o
);
  logic           inc;
  logic [OUT_W:0] sum;

  // only non-negative magnitudes reach this stage
  always_comb begin
    unique case (mode_i)
      RM_NEAR: inc = guard_i && (sticky_i || int_i[0]);
      RM_UP:   inc = guard_i || sticky_i;
      default: inc = 1'b0;
    endcase
    sum       = {1'b0, int_i} + {{OUT_W{1'b0}}, inc};
    val_o     = sum[OUT_W-1:0];
    ovf_o     = sum[OUT_W] || (!wide_i && (sum[OUT_W-1:NARROW_W] != '0));
    inexact_o = guard_i || sticky_i;
  end
endmodule

// File: rtl/f2u_conv.sv
module f2u_conv
  import f2u_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OUT_W-1:0] in_operand,
  input  logic             in_is_double,
  input  logic             in_wide,
  input  logic             in_chop,
  input  logic [1:0]       in_rmode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_result,
  output logic             out_invalid,
  output logic             out_inexact
);
  unpacked_t        fld_sp;
  unpacked_t        fld_dp;
  unpacked_t        fld;
  logic [OUT_W-1:0] int_part;
  logic             guard;
  logic             sticky;
  logic             big;
  logic [OUT_W-1:0] rounded;
  logic             ovf;
  logic             rnd_inexact;
  rmode_e           eff_mode;
  logic [OUT_W-1:0] ones;
  logic [OUT_W-1:0] nxt_result;
  logic             nxt_invalid;
  logic             nxt_inexact;
  logic             accept;

  f2u_field_dec #(.EW(SP_EXP), .FW(SP_FRAC)) u_dec_sp (
    .bits_i   (in_operand[SP_EXP+SP_FRAC:0]),
    .fields_o (fld_sp)
  );

  f2u_field_dec #(.EW(DP_EXP), .FW(DP_FRAC)) u_dec_dp (
    .bits_i   (in_operand[DP_EXP+DP_FRAC:0]),
    .fields_o (fld_dp)
  );

  assign fld      = in_is_double ? fld_dp : fld_sp;
  assign eff_mode = in_chop ? RM_ZERO : rmode_e'(in_rmode);

  f2u_align u_align (
    .fields_i (fld),
    .int_o    (int_part),
    .guard_o  (guard),
    .sticky_o (sticky),
    .big_o    (big)
  );

  f2u_round u_round (
    .int_i     (int_part),
    .guard_i   (guard),
    .sticky_i  (sticky),
    .mode_i    (eff_mode),
    .wide_i    (in_wide),
    .val_o     (rounded),
    .ovf_o     (ovf),
    .inexact_o (rnd_inexact)
  );

  // classification precedes rounding: NaN, zero, sign, then range
  always_comb begin
    ones        = in_wide ? '1 : OUT_W'({NARROW_W{1'b1}});
    nxt_result  = rounded;
    nxt_invalid = 1'b0;
    nxt_inexact = rnd_inexact;
    if (fld.is_nan) begin
      nxt_result  = ones;
      nxt_invalid = 1'b1;
      nxt_inexact = 1'b0;
    end else if (fld.is_zero) begin
      nxt_result  = '0;
      nxt_inexact = 1'b0;
    end else if (fld.sign) begin
      nxt_result  = '0;
      nxt_invalid = 1'b1;
      nxt_inexact = 1'b0;
    end else if (fld.is_inf || big || ovf) begin
      nxt_result  = ones;
      nxt_invalid = 1'b1;
      nxt_inexact = 1'b0;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= nxt_result;
      out_invalid <= nxt_invalid;
      out_inexact <= nxt_inexact;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/f2u_conv_chk.sv
module f2u_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_operand,
  input logic        in_is_double,
  input logic        in_wide,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_invalid,
  input logic        out_inexact
);
  logic acc;
  logic op_sign;
  logic op_eones;
  logic op_ezero;
  logic op_fnz;
  logic op_nan;
  logic op_negzero;
  logic op_negbad;

  always_comb begin
    acc = in_valid && in_ready;
    if (in_is_double) begin
      op_sign  = in_operand[63];
      op_eones = &in_operand[62:52];
      op_ezero = ~|in_operand[62:52];
      op_fnz   = |in_operand[51:0];
    end else begin
      op_sign  = in_operand[31];
      op_eones = &in_operand[30:23];
      op_ezero = ~|in_operand[30:23];
      op_fnz   = |in_operand[22:0];
    end
    op_nan     = op_eones && op_fnz;
    op_negzero = op_sign && op_ezero && !op_fnz;
    op_negbad  = op_sign && !op_nan && !(op_ezero && !op_fnz);
  end

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R1
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
      && $stable(out_invalid) && $stable(out_inexact))); // R1
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_wide) |=> (out_result[63:32] == 32'h0)); // R2
  AST_NAN_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_nan) |=> (out_invalid && !out_inexact && out_result[31:0] == 32'hffff_ffff)); // R3
  AST_NEG_NONZERO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_negbad) |=> (out_invalid && !out_inexact && out_result == 64'h0)); // R4
  AST_NEG_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_negzero) |=> (!out_invalid && !out_inexact && out_result == 64'h0)); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact)); // R8
endmodule

bind f2u_conv f2u_conv_chk u_chk (.*);

// File: tb/f2u_conv_tb.sv
module f2u_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_operand;
  logic        in_is_double;
  logic        in_wide;
  logic        in_chop;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_result;
  logic        out_invalid;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  f2u_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_is_double(in_is_double), .in_wide(in_wide),
    .in_chop(in_chop), .in_rmode(in_rmode), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_invalid(out_invalid),
    .out_inexact(out_inexact)
  );

  // {operand, dbl, wide, chop, rmode, expected result, invalid, inexact}
  localparam int NV = 29;
  localparam logic [134:0] VEC [NV] = '{
    {64'h3FC00000,         3'b000, 2'b00, 64'h2,                 2'b01}, // R7 1.5 nearest
    {64'h40200000,         3'b000, 2'b00, 64'h2,                 2'b01}, // R7 2.5 tie even
    {64'h40200000,         3'b000, 2'b11, 64'h3,                 2'b01}, // R7 2.5 up
    {64'h40200000,         3'b000, 2'b10, 64'h2,                 2'b01}, // R7 2.5 down
    {64'h40200000,         3'b001, 2'b11, 64'h2,                 2'b01}, // R7 chop beats up
    {64'h40400000,         3'b000, 2'b00, 64'h3,                 2'b00}, // R8 exact 3.0
    {64'hBE800000,         3'b000, 2'b00, 64'h0,                 2'b10}, // R4 -0.25
    {64'h80000000,         3'b000, 2'b00, 64'h0,                 2'b00}, // R5 -0 single
    {64'h7FC00000,         3'b000, 2'b00, 64'hFFFFFFFF,          2'b10}, // R3 qNaN narrow
    {64'hFF800001,         3'b010, 2'b00, 64'hFFFFFFFFFFFFFFFF,  2'b10}, // R3 neg sNaN wide
    {64'h7F800000,         3'b000, 2'b00, 64'hFFFFFFFF,          2'b10}, // R6 +inf
    {64'hFF800000,         3'b000, 2'b00, 64'h0,                 2'b10}, // R4 -inf
    {64'h4F800000,         3'b000, 2'b00, 64'hFFFFFFFF,          2'b10}, // R6 2^32 narrow
    {64'h4F800000,         3'b010, 2'b00, 64'h100000000,         2'b00}, // R2 2^32 wide
    {64'h41EFFFFFFFF00000, 3'b100, 2'b00, 64'hFFFFFFFF,          2'b10}, // R6 rounds out
    {64'h41EFFFFFFFF00000, 3'b101, 2'b00, 64'hFFFFFFFF,          2'b01}, // R8 chop keeps
    {64'h41EFFFFFFFF00000, 3'b110, 2'b00, 64'h100000000,         2'b01}, // R2 wide carry
    {64'hFFFFFF7F00000001, 3'b101, 2'b00, 64'hFFFFFFFF,          2'b10}, // R3 double NaN chop
    {64'h8000000000000000, 3'b111, 2'b00, 64'h0,                 2'b00}, // R5 -0 double
    {64'h0000000000000001, 3'b110, 2'b11, 64'h1,                 2'b01}, // R9 denorm up
    {64'h0000000000000001, 3'b110, 2'b00, 64'h0,                 2'b01}, // R9 denorm near
    {64'h00000001,         3'b000, 2'b11, 64'h1,                 2'b01}, // R9 single denorm
    {64'h43F0000000000000, 3'b110, 2'b00, 64'hFFFFFFFFFFFFFFFF,  2'b10}, // R6 2^64
    {64'h43E0000000000000, 3'b110, 2'b00, 64'h8000000000000000,  2'b00}, // R2 2^63
    {64'h80000001,         3'b000, 2'b00, 64'h0,                 2'b10}, // R4 neg denorm
    {64'h3FE0000000000000, 3'b100, 2'b00, 64'h0,                 2'b01}, // R7 0.5 near
    {64'h3FE0000000000000, 3'b100, 2'b11, 64'h1,                 2'b01}, // R7 0.5 up
    {64'h7FEFFFFFFFFFFFFF, 3'b110, 2'b00, 64'hFFFFFFFFFFFFFFFF,  2'b10}, // R6 max double
    {64'h405EC00000000000, 3'b110, 2'b00, 64'h7B,                2'b00}  // R8 123.0
  };

  task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [134:0] v);
    in_operand   = v[134:71];
    in_is_double = v[70];
    in_wide      = v[69];
    in_chop      = v[68];
    in_rmode     = v[67:66];
    in_valid     = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_operand = '0; in_is_double = 1'b0; in_wide = 1'b0; in_chop = 1'b0; in_rmode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset valid/ready", {64'h0, out_valid, in_ready}, {64'h0, 1'b0, 1'b1});
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R1 vec%0d valid", i), {65'h0, out_valid}, {65'h0, 1'b1});
      check($sformatf("vec%0d result/flags", i),
            {out_result, out_invalid, out_inexact}, VEC[i][65:0]);
    end

    // R1 back-pressure: hold first result, second operand waits
    @(negedge clk);
    out_ready = 1'b0;
    drive(VEC[5]);                       // 3.0 exact
    @(negedge clk);
    drive(VEC[28]);                      // 123.0 waits
    check("R1 stall ready low", {65'h0, in_ready}, {65'h0, 1'b0});
    @(negedge clk);
    check("R1 stall hold", {out_result, out_valid, out_invalid}, {64'h3, 1'b1, 1'b0});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second after release", {out_result, out_invalid, out_inexact}, {64'h7B, 2'b00});
    @(negedge clk);
    check("R1 drained", {65'h0, out_valid}, {65'h0, 1'b0});

    // R7 all modes on 1.5 (expect 2,1,1,2)
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      drive({64'h3FC00000, 3'b000, 2'(m), 66'h0});
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R7 1.5 mode %0d", m), {out_result, out_invalid, out_inexact},
            {((m == 1 || m == 2) ? 64'h1 : 64'h2), 2'b01});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule